// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits beside a CAN receiver and decides, for each received message, whether its identifier passes a bank of eight acceptance code bytes and eight mask bytes. A mask bit of 1 turns the matching identifier bit into a don't-care. A two-bit mode field selects how the bank is split:

- two filters that each compare four identifier bytes;
- four filters that each compare two identifier bytes;
- eight filters that each compare one identifier byte;
- a closed setting that accepts nothing.

Every message gets a verdict one cycle after its identifier is presented. That verdict is an accept flag plus the index of the lowest-numbered filter that matched.

The index of each accepted message goes into a small queue that runs in step with the receive message store. The hit index that software sees is loaded from the head of that queue only when a message moves into the foreground receive buffer. The visible index therefore always describes the foreground message, not the latest frame on the bus.

The mode field and the filter bank can only be written while initialization is both requested and acknowledged.

Top module: `can_id_accept_filter`

## Requirements
- R1: After a synchronous reset, the mode field is 00, the visible hit index is 000, `ctrl_rdata` reads 0x00 and `acc_valid` is low.
- R2: A control write changes the mode field only when `init_req` and `init_ack` are both high in the same cycle; any other control write leaves `ctrl_rdata` unchanged.
- R3: `ctrl_rdata` holds the mode field in bits [1:0] and the visible hit index in bits [6:4]; bits 7, 3 and 2 always read 0. Control writes never alter bits [6:4].
- R4: In mode 00, filter f (f = 0..1) accepts when, for each j = 0..3, identifier byte j (`id_bytes[8j+7:8j]`) equals code byte 4f+j on every bit where mask byte 4f+j is 0.
- R5: In mode 01, filter f (f = 0..3) compares identifier bytes 0 and 1 against code and mask bytes 2f and 2f+1, using the same masking rule.
- R6: In mode 10, filter f (f = 0..7) compares identifier byte 0 against code byte f under mask byte f.
- R7: In mode 11, no message is accepted. `acc_flag` stays low and nothing is queued, so a later foreground shift leaves the hit index unchanged.
- R8: When several filters match, the reported index is that of the lowest-numbered matching filter.
- R9: The cycle after `id_valid` is sampled, `acc_valid` is high for one cycle with `acc_flag` and `acc_idx`; `acc_idx` is 0 when the message is not accepted.
- R10: The visible hit index changes only on an `fg_shift` edge. On that edge it takes the oldest queued accepted index, in arrival order. A shift with an empty queue leaves it unchanged.
- R11: The queue holds FIFO_DEPTH (default 4) indices. An accepted message that arrives while the queue is full and no pop happens is dropped, and its index never becomes visible.
- R12: When a push and a pop fall on the same edge, both take effect; a pop frees the slot for the push even when the queue is full.
- R13: A bank write (`bank_mask_sel` 0 selects code and 1 selects mask; `bank_addr` selects byte 0..7) takes effect only when `init_req` and `init_ack` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data; mode field in [1:0] |
| init_req | input | 1 | Initialization requested |
| init_ack | input | 1 | Initialization acknowledged |
| bank_we | input | 1 | Filter bank write strobe |
| bank_mask_sel | input | 1 | 0 = code byte, 1 = mask byte |
| bank_addr | input | 3 | Bank byte index |
| bank_wdata | input | 8 | Bank write data |
| id_valid | input | 1 | Identifier bytes valid this cycle |
| id_bytes | input | 32 | Received identifier bytes, byte j at [8j+7:8j] |
| fg_shift | input | 1 | Message moves into the foreground buffer |
| acc_valid | output | 1 | Verdict valid |
| acc_flag | output | 1 | Message accepted |
| acc_idx | output | 3 | Matching filter index of the verdict |
| hit_idx | output | 3 | Visible hit index for the foreground message |
| ctrl_rdata | output | 8 | Control register read value |

## Verification
An accepted message can arrive on the same edge as a foreground shift, so a queue push and a queue pop then coincide. The bench provokes this throughout its sweeps by raising `fg_shift` on every other message. It also does so deliberately with the queue full, where the pop must free the slot that the push needs. A queue model in the bench, updated pop-first and then push, gives the index that `hit_idx` must show after each edge. The drained order then shows whether any entry was lost or duplicated.

// File: rtl/idf_pkg.sv
package idf_pkg;

    localparam int unsigned BANK_BYTES = 8;
    localparam int unsigned IDX_W      = $clog2(BANK_BYTES);
    localparam int unsigned ID_BYTES   = 4;
    localparam int unsigned CTRL_W     = 8;

    typedef enum logic [1:0] {
        MODE_W32  = 2'b00,
        MODE_W16  = 2'b01,
        MODE_W8   = 2'b10,
        MODE_SHUT = 2'b11
    } idf_mode_e;

    typedef struct packed {
        logic             accept;
        logic [IDX_W-1:0] idx;
    } idf_result_t;

    // byte passes when every bit not masked agrees
    function automatic logic byte_pass(input logic [7:0] id_b,
                                       input logic [7:0] code_b,
                                       input logic [7:0] mask_b);
        return ((id_b ^ code_b) & ~mask_b) == 8'h00;
    endfunction

endpackage

// File: rtl/idf_bank.sv
module idf_bank
    import idf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_mask,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic [7:0]              wr_data,
    output logic [BANK_BYTES*8-1:0] code_o,
    output logic [BANK_BYTES*8-1:0] mask_o
);

    logic [7:0] code_q [BANK_BYTES];
    logic [7:0] mask_q [BANK_BYTES];

    for (genvar k = 0; k < BANK_BYTES; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[k] <= 8'h00;
                mask_q[k] <= 8'h00;
            end else if (wr_en && wr_addr == IDX_W'(k)) begin
                if (wr_mask) mask_q[k] <= wr_data;
                else         code_q[k] <= wr_data;
            end
        end
        assign code_o[8*k +: 8] = code_q[k];
        assign mask_o[8*k +: 8] = mask_q[k];
    end

endmodule

// File: rtl/idf_match.sv
module idf_match
    import idf_pkg::*;
(
    input  idf_mode_e               mode,
    input  logic [ID_BYTES*8-1:0]   id_bytes,
    input  logic [BANK_BYTES*8-1:0] code,
    input  logic [BANK_BYTES*8-1:0] mask,
    output idf_result_t             res
);

    localparam int unsigned N32 = BANK_BYTES / 4;
    localparam int unsigned N16 = BANK_BYTES / 2;

    logic [BANK_BYTES-1:0] ok32, ok16, ok8;
    logic [N32-1:0]        hit32;
    logic [N16-1:0]        hit16;
    logic [BANK_BYTES-1:0] hits;

    // each bank byte compared against the id byte it faces in each split
    for (genvar k = 0; k < BANK_BYTES; k++) begin : g_cmp
        assign ok32[k] = byte_pass(id_bytes[8*(k%4) +: 8], code[8*k +: 8], mask[8*k +: 8]);
        assign ok16[k] = byte_pass(id_bytes[8*(k%2) +: 8], code[8*k +: 8], mask[8*k +: 8]);
        assign ok8[k]  = byte_pass(id_bytes[7:0],          code[8*k +: 8], mask[8*k +: 8]);
    end

    for (genvar f = 0; f < N32; f++) begin : g_f32
        assign hit32[f] = &ok32[4*f +: 4];
    end

    for (genvar f = 0; f < N16; f++) begin : g_f16
        assign hit16[f] = &ok16[2*f +: 2];
    end

    always_comb begin
        hits = '0;
        unique case (mode)
            MODE_W32:  hits[N32-1:0] = hit32;
            MODE_W16:  hits[N16-1:0] = hit16;
            MODE_W8:   hits          = ok8;
            MODE_SHUT: hits          = '0;
            default:   hits          = '0;
        endcase
    end

    // lowest-numbered filter wins
    always_comb begin
        res.accept = |hits;
        res.idx    = '0;
        for (int i = BANK_BYTES - 1; i >= 0; i--) begin
            if (hits[i]) res.idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/idf_hit_queue.sv
module idf_hit_queue
    import idf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] hit_q
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] slot_q [DEPTH];
    logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    count_q;
    logic             pop_ok, push_ok, full;

    assign full    = (count_q == CW'(DEPTH));
    assign pop_ok  = pop && (count_q != '0);
    assign push_ok = push && (!full || pop_ok);

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            hit_q    <= '0;
        end else begin
            if (push_ok) begin
                slot_q[wr_ptr_q] <= push_idx;
                wr_ptr_q         <= nxt(wr_ptr_q);
            end
            if (pop_ok) begin
                hit_q    <= slot_q[rd_ptr_q];
                rd_ptr_q <= nxt(rd_ptr_q);
            end
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    a_r10_hit_hold: assert property (@(posedge clk) disable iff (rst)
        !pop |=> $stable(hit_q));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));

    a_r12_push_pop_level: assert property (@(posedge clk) disable iff (rst)
        (push && pop && count_q != '0) |=> count_q == $past(count_q));

    a_r11_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && full) |=> full);

endmodule

// File: rtl/can_id_accept_filter.sv
module can_id_accept_filter
    import idf_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CTRL_W-1:0]     cfg_wdata,
    input  logic                  init_req,
    input  logic                  init_ack,
    input  logic                  bank_we,
    input  logic                  bank_mask_sel,
    input  logic [IDX_W-1:0]      bank_addr,
    input  logic [7:0]            bank_wdata,
    input  logic                  id_valid,
    input  logic [ID_BYTES*8-1:0] id_bytes,
    input  logic                  fg_shift,
    output logic                  acc_valid,
    output logic                  acc_flag,
    output logic [IDX_W-1:0]      acc_idx,
    output logic [IDX_W-1:0]      hit_idx,
    output logic [CTRL_W-1:0]     ctrl_rdata
);

    logic                    init_ok;
    idf_mode_e               mode_q;
    logic [BANK_BYTES*8-1:0] code_w, mask_w;
    idf_result_t             res_w;
    logic                    unused_wbits;

    assign init_ok      = init_req && init_ack;
    assign unused_wbits = ^cfg_wdata[CTRL_W-1:2];

    always_ff @(posedge clk) begin
        if (rst)                      mode_q <= MODE_W32;
        else if (cfg_we && init_ok)   mode_q <= idf_mode_e'(cfg_wdata[1:0]);
    end

    idf_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bank_we && init_ok),
        .wr_mask (bank_mask_sel),
        .wr_addr (bank_addr),
        .wr_data (bank_wdata),
        .code_o  (code_w),
        .mask_o  (mask_w)
    );

    idf_match u_match (
        .mode     (mode_q),
        .id_bytes (id_bytes),
        .code     (code_w),
        .mask     (mask_w),
        .res      (res_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid <= 1'b0;
            acc_flag  <= 1'b0;
            acc_idx   <= '0;
        end else begin
            acc_valid <= id_valid;
            acc_flag  <= id_valid && res_w.accept;
            acc_idx   <= id_valid ? res_w.idx : '0;
        end
    end

    idf_hit_queue #(.DEPTH(FIFO_DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (id_valid && res_w.accept),
        .push_idx (res_w.idx),
        .pop      (fg_shift),
        .hit_q    (hit_idx)
    );

    assign ctrl_rdata = {1'b0, hit_idx, 2'b00, mode_q};

    a_r2_mode_locked: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && init_ok) |=> $stable(mode_q));

    a_r7_closed_rejects: assert property (@(posedge clk) disable iff (rst)
        (id_valid && mode_q == MODE_SHUT) |=> (acc_valid && !acc_flag));

    a_r9_verdict_timing: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> acc_valid);

    a_r9_no_stray_verdict: assert property (@(posedge clk) disable iff (rst)
        !id_valid |=> !acc_valid);

    a_r9_reject_idx_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_flag) |-> acc_idx == '0);

endmodule

// File: tb/can_id_accept_filter_tb_top.sv
`timescale 1ns/1ps
module can_id_accept_filter_tb_top;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, init_req, init_ack;
    logic [7:0]  cfg_wdata;
    logic        bank_we, bank_mask_sel;
    logic [2:0]  bank_addr;
    logic [7:0]  bank_wdata;
    logic        id_valid, fg_shift;
    logic [31:0] id_bytes;
    logic        acc_valid, acc_flag;
    logic [2:0]  acc_idx, hit_idx;
    logic [7:0]  ctrl_rdata;

    always #2.5 clk = ~clk;

    can_id_accept_filter #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .init_req(init_req), .init_ack(init_ack), .bank_we(bank_we),
        .bank_mask_sel(bank_mask_sel), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .id_valid(id_valid), .id_bytes(id_bytes),
        .fg_shift(fg_shift), .acc_valid(acc_valid), .acc_flag(acc_flag),
        .acc_idx(acc_idx), .hit_idx(hit_idx), .ctrl_rdata(ctrl_rdata)
    );

    int checks = 0;
    int errors = 0;

    // reference state
    logic [7:0] bc [8];
    logic [7:0] bm [8];
    logic [1:0] mode_m = 2'b00;
    logic [2:0] q_m [DEPTH];
    int         cnt_m = 0;
    logic [2:0] exp_hit = 3'd0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_match(input logic [1:0] m, input logic [31:0] id);
        int w;
        bit ok;
        if (m == 2'b11) return 4'h0;
        w = (m == 2'b00) ? 4 : (m == 2'b01) ? 2 : 1;
        for (int f = 0; f < 8 / w; f++) begin
            ok = 1'b1;
            for (int j = 0; j < w; j++)
                if (((id[8*j +: 8] ^ bc[f*w+j]) & ~bm[f*w+j]) != 8'h00) ok = 1'b0;
            if (ok) return {1'b1, 3'(f)};
        end
        return 4'h0;
    endfunction

    function automatic logic [7:0] exp_rdata();
        return {1'b0, exp_hit, 2'b00, mode_m};
    endfunction

    task automatic cfg_write(input logic [7:0] d, input logic rq, input logic ak);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d; init_req = rq; init_ack = ak;
        @(posedge clk);
        if (rq && ak) mode_m = d[1:0];
        @(negedge clk);
        cfg_we = 1'b0; init_req = 1'b0; init_ack = 1'b0;
    endtask

    task automatic bank_write(input logic ms, input logic [2:0] a, input logic [7:0] d,
                              input logic rq, input logic ak);
        @(negedge clk);
        bank_we = 1'b1; bank_mask_sel = ms; bank_addr = a; bank_wdata = d;
        init_req = rq; init_ack = ak;
        @(posedge clk);
        if (rq && ak) begin
            if (ms) bm[a] = d; else bc[a] = d;
        end
        @(negedge clk);
        bank_we = 1'b0; init_req = 1'b0; init_ack = 1'b0;
    endtask

    task automatic step(input logic v, input logic [31:0] id, input logic sh, input string tag);
        logic [3:0] r;
        bit do_pop, do_push;
        @(negedge clk);
        id_valid = v; id_bytes = id; fg_shift = sh;
        @(posedge clk);
        r       = ref_match(mode_m, id);
        do_pop  = sh && (cnt_m > 0);
        do_push = v && r[3] && (cnt_m < DEPTH || do_pop);
        if (do_pop) begin
            exp_hit = q_m[0];
            for (int i = 0; i < DEPTH - 1; i++) q_m[i] = q_m[i+1];
            cnt_m--;
        end
        if (do_push) begin
            q_m[cnt_m] = r[2:0];
            cnt_m++;
        end
        @(negedge clk);
        id_valid = 1'b0; fg_shift = 1'b0;
        if (v)
            check(acc_valid && acc_flag == r[3] && acc_idx == r[2:0], tag,
                  {27'd0, acc_valid, acc_flag, acc_idx}, {27'd0, 1'b1, r});
        check(hit_idx == exp_hit, "R10 visible hit index", {29'd0, hit_idx}, {29'd0, exp_hit});
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 32'h0, 1'b1, "R10 drain");
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_we = 0; cfg_wdata = 0; init_req = 0; init_ack = 0;
        bank_we = 0; bank_mask_sel = 0; bank_addr = 0; bank_wdata = 0;
        id_valid = 0; id_bytes = 0; fg_shift = 0;
        for (int i = 0; i < 8; i++) begin bc[i] = 8'h00; bm[i] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(ctrl_rdata == 8'h00, "R1 rdata", {24'd0, ctrl_rdata}, 32'h0);
        check(hit_idx == 3'd0, "R1 hit", {29'd0, hit_idx}, 32'h0);
        check(acc_valid == 1'b0, "R1 acc_valid", {31'd0, acc_valid}, 32'h0);

        // R2 writes outside full init handshake are ignored
        cfg_write(8'h02, 1'b1, 1'b0);
        check(ctrl_rdata == exp_rdata(), "R2 req only", {24'd0, ctrl_rdata}, {24'd0, exp_rdata()});
        cfg_write(8'h03, 1'b0, 1'b1);
        check(ctrl_rdata == exp_rdata(), "R2 ack only", {24'd0, ctrl_rdata}, {24'd0, exp_rdata()});

        // R3 hit bits and unused bits not writable
        cfg_write(8'hFF, 1'b1, 1'b1);
        check(ctrl_rdata == 8'h03, "R3 layout", {24'd0, ctrl_rdata}, 32'h03);

        // program bank: code k = 16k+5
        for (int k = 0; k < 8; k++) bank_write(1'b0, 3'(k), 8'(16*k + 5), 1'b1, 1'b1);
        bank_write(1'b1, 3'd0, 8'h0F, 1'b1, 1'b1);
        bank_write(1'b1, 3'd2, 8'hF0, 1'b1, 1'b1);
        bank_write(1'b1, 3'd4, 8'h03, 1'b1, 1'b1);
        bank_write(1'b1, 3'd6, 8'h81, 1'b1, 1'b1);
        bank_write(1'b1, 3'd7, 8'hFF, 1'b1, 1'b1);

        // R6 / R8 eight byte filters, full sweep of byte 0
        cfg_write(8'h02, 1'b1, 1'b1);
        check(ctrl_rdata == exp_rdata(), "R2 mode write", {24'd0, ctrl_rdata}, {24'd0, exp_rdata()});
        for (int i = 0; i < 256; i++)
            step(1'b1, {24'hA5C3E1, 8'(i)}, 1'(i), "R6 R8 eight filters");

        // R13 bank write outside init ignored
        bank_write(1'b0, 3'd1, 8'h77, 1'b1, 1'b0);
        step(1'b1, 32'h0000_0015, 1'b0, "R13 bank lock");
        drain();

        // R5 four 16-bit filters
        cfg_write(8'h01, 1'b1, 1'b1);
        for (int i = 0; i < 256; i++)
            step(1'b1, {16'h0, 8'(i), 8'h25}, 1'(i), "R5 sweep byte1");
        for (int i = 0; i < 256; i++)
            step(1'b1, {16'h0, 8'h00, 8'(i)}, 1'(i), "R5 sweep byte0");
        drain();

        // R4 two 32-bit filters
        cfg_write(8'h00, 1'b1, 1'b1);
        for (int i = 0; i < 256; i++)
            step(1'b1, {8'h35, 8'(i), 8'h15, 8'h05}, 1'(i), "R4 filter0 sweep");
        for (int i = 0; i < 256; i++)
            step(1'b1, {8'(i), 8'h65, 8'h55, 8'h45}, 1'(i), "R4 filter1 sweep");
        drain();

        // R7 closed mode
        cfg_write(8'h03, 1'b1, 1'b1);
        for (int i = 0; i < 32; i++)
            step(1'b1, 32'h0101_0101 * i, 1'b0, "R7 closed");
        step(1'b0, 32'h0, 1'b1, "R7 nothing queued");
        step(1'b0, 32'h0, 1'b1, "R7 nothing queued");

        // R11 overflow and R12 simultaneous push/pop
        cfg_write(8'h02, 1'b1, 1'b1);
        step(1'b1, 32'h05, 1'b0, "R11 fill");
        step(1'b1, 32'h15, 1'b0, "R11 fill");
        step(1'b1, 32'h25, 1'b0, "R11 fill");
        step(1'b1, 32'h35, 1'b0, "R11 fill");
        step(1'b1, 32'h45, 1'b0, "R11 dropped");
        step(1'b1, 32'h55, 1'b0, "R11 dropped");
        step(1'b1, 32'h65, 1'b1, "R12 push pop full");
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 32'h0, 1'b1, "R11 R12 drain order");
        check(ctrl_rdata == exp_rdata(), "R3 hit in rdata", {24'd0, ctrl_rdata}, {24'd0, exp_rdata()});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule